// File: doc/BRIEF.md
# Power-Fail and Pushbutton Reset Sequencer

This block owns a single open-drain, active-low system reset line. It pulls that line low while the supply is out of tolerance and keeps it low for a fixed hold time once the supply recovers. It also accepts a watchdog reset request and answers it with a fixed-length low pulse. The same line doubles as a pushbutton input. A press seen while the block is idle starts a hold. When that hold ends, the block lets go of the line and waits for the button to come up, then drives the line low for a second full hold.

All hold times are counted in ticks of a 4096 Hz strobe. The default hold of 1024 ticks gives 250 ms. When the oscillator is configured to stop in standby, the power-up hold begins only after the oscillator reports that it is running, so the reset covers the startup time as well. A register-access inhibit goes with every reset cycle, so an outer block can stop bus traffic.

Top module: `rst_seq_gen`

## Requirements
- R1: While `pwrFail` is high, `pullLow` and `inhibit` are both 1 from the cycle after it is sampled high. A logic reset puts the block into this same power-fail state.
- R2: When `pwrFail` falls with `oscOff`=0, the line stays low for `HOLD_TICKS` ticks after the power-fail state is left, and is released only in the cycle after a tick.
- R3: When `pwrFail` falls with `oscOff`=1 and `oscReady`=0, the line stays low until `oscReady` is 1, and then for a further `HOLD_TICKS` ticks.
- R4: In idle, a high-to-low change of the pin, seen after `SYNC_STAGES`=2 synchronizer flops, pulls the line low for `HOLD_TICKS` ticks. `pullLow` rises on the third clock edge after the pin falls.
- R5: After that hold, `pullLow` returns to 0 and `inhibit` stays 1 until the synchronized pin reads high. The line is then pulled low for another `HOLD_TICKS` ticks, after which the block returns to idle.
- R6: A `wdReq` sampled in idle produces a low pulse of `HOLD_TICKS` ticks. Neither further `wdReq` nor pin activity during the pulse shortens or lengthens it.
- R7: The pin is acted on only in idle. The low level the block causes itself, and any press that begins and ends outside idle, start no new cycle. Idle with no request stays idle.
- R8: `pwrFail` overrides every state and restarts the power sequence. Any pushbutton sequence in progress is dropped.
- R9: `inhibit` is 1 in every non-idle state, and therefore whenever `pullLow` is 1. It is 0 in idle.
- R10: When `wdReq` and a detected pin fall occur in the same idle cycle, the pushbutton sequence, including its wait for release, is the one taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low logic reset |
| pwrFail | input | 1 | Synchronized supply-out-of-tolerance indication |
| pinIn | input | 1 | Raw level read back from the reset pin |
| wdReq | input | 1 | Watchdog reset request strobe |
| oscOff | input | 1 | Oscillator configured to stop in standby |
| oscReady | input | 1 | Oscillator running and stable |
| tick | input | 1 | One-cycle 4096 Hz timing strobe |
| pullLow | output | 1 | Enables the open-drain pull-down on the reset pin |
| inhibit | output | 1 | Blocks register access while a reset cycle is active |

## Verification
Two functions can fall in the same idle cycle: the watchdog request and the synchronized detection of a button press. The bench raises `wdReq` exactly two negative edges after the button goes down, so that the request lands in the cycle where the delayed pin fall is decoded. The result is judged after one full hold time with the button still held. There `pullLow` must be 0 while `inhibit` is still 1, because the block is waiting for release. A watchdog pulse would instead have returned the block to idle. The per-cycle model compares both outputs on every clock through this window.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR_DOWN,
    ST_OSC_WAIT,
    ST_PWR_HOLD,
    ST_PB_HOLD,
    ST_PB_REL,
    ST_PB_RHOLD,
    ST_WD_HOLD
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // restart the hold tick counter
    logic edgeArm;  // pin edges are meaningful (block idle, not driving)
  } seq_strobe_t;

endpackage

// File: rtl/rstgen_dp.sv
module rstgen_dp
  import rstgen_pkg::*;
#(
  parameter int HOLD_TICKS  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  logic        tick,
  input  seq_strobe_t strobe,
  output logic        pinLvl,
  output logic        pinFall,
  output logic        holdDone
);

  localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic [CNT_W-1:0]       cnt;

  // pin synchronizer; idle pin level is high (pulled up)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      prevLvl <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevLvl <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinLvl  = syncQ[SYNC_STAGES-1];
  assign pinFall = strobe.edgeArm & prevLvl & ~pinLvl;

  // hold-time tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (tick)          cnt <= cnt + 1'b1;
  end

  assign holdDone = tick && (cnt == CNT_LAST);

endmodule

// File: rtl/rstgen_ctrl.sv
module rstgen_ctrl
  import rstgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrFail,
  input  logic        wdReq,
  input  logic        oscOff,
  input  logic        oscReady,
  input  logic        pinLvl,
  input  logic        pinFall,
  input  logic        holdDone,
  output seq_strobe_t strobe,
  output logic        pullLow,
  output logic        inhibit
);

  seq_state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PWR_DOWN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        // pushbutton wins over watchdog in the same cycle
        if (pinFall)    nextState = ST_PB_HOLD;
        else if (wdReq) nextState = ST_WD_HOLD;
      end
      ST_PWR_DOWN:  nextState = (oscOff && !oscReady) ? ST_OSC_WAIT : ST_PWR_HOLD;
      ST_OSC_WAIT:  if (oscReady) nextState = ST_PWR_HOLD;
      ST_PWR_HOLD:  if (holdDone) nextState = ST_IDLE;
      ST_PB_HOLD:   if (holdDone) nextState = ST_PB_REL;
      ST_PB_REL:    if (pinLvl)   nextState = ST_PB_RHOLD;
      ST_PB_RHOLD:  if (holdDone) nextState = ST_IDLE;
      ST_WD_HOLD:   if (holdDone) nextState = ST_IDLE;
      default:      nextState = ST_PWR_DOWN;
    endcase
    if (pwrFail) nextState = ST_PWR_DOWN;
  end

  always_comb begin
    strobe.cntClr  = (nextState != state);
    strobe.edgeArm = (state == ST_IDLE);
  end

  assign pullLow = (state != ST_IDLE) && (state != ST_PB_REL);
  assign inhibit = (state != ST_IDLE);

endmodule

// File: rtl/rst_seq_gen.sv
module rst_seq_gen
  import rstgen_pkg::*;
#(
  parameter int HOLD_TICKS  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrFail,
  input  logic pinIn,
  input  logic wdReq,
  input  logic oscOff,
  input  logic oscReady,
  input  logic tick,
  output logic pullLow,
  output logic inhibit
);

  seq_strobe_t strobe;
  logic pinLvl, pinFall, holdDone;

  rstgen_dp #(
    .HOLD_TICKS (HOLD_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .tick    (tick),
    .strobe  (strobe),
    .pinLvl  (pinLvl),
    .pinFall (pinFall),
    .holdDone(holdDone)
  );

  rstgen_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwrFail (pwrFail),
    .wdReq   (wdReq),
    .oscOff  (oscOff),
    .oscReady(oscReady),
    .pinLvl  (pinLvl),
    .pinFall (pinFall),
    .holdDone(holdDone),
    .strobe  (strobe),
    .pullLow (pullLow),
    .inhibit (inhibit)
  );

endmodule

// File: rtl/rst_seq_gen_chk.sv
module rst_seq_gen_chk (
  input logic clk,
  input logic rstN,
  input logic pwrFail,
  input logic wdReq,
  input logic tick,
  input logic pinFall,
  input logic pullLow,
  input logic inhibit
);

  p_pf_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> (pullLow && inhibit));

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullLow) |-> $past(tick));

  p_pb_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibit && pinFall && !pwrFail) |=> pullLow);

  p_wd_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibit && wdReq && !pwrFail) |=> pullLow);

  p_idle_stays_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibit && !pwrFail && !wdReq && !pinFall) |=> !inhibit);

  p_inhibit_cover_r9: assert property (@(posedge clk) disable iff (!rstN)
    pullLow |-> inhibit);

endmodule

bind rst_seq_gen rst_seq_gen_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .pwrFail(pwrFail),
  .wdReq  (wdReq),
  .tick   (tick),
  .pinFall(pinFall),
  .pullLow(pullLow),
  .inhibit(inhibit)
);

// File: tb/rst_seq_gen_tb.sv
module rst_seq_gen_tb;

  localparam int HOLD = 8;
  localparam int TDIV = 4;
  localparam int HT   = HOLD * TDIV;

  // model modes
  localparam int M_IDLE = 0, M_PD = 1, M_OSC = 2, M_PH = 3,
                 M_PB = 4, M_REL = 5, M_RH = 6, M_WD = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0, pwrFail = 1'b1, wdReq = 1'b0;
  logic oscOff = 1'b0, oscReady = 1'b1, tick = 1'b0, btn = 1'b0;
  logic pullLow, inhibit;
  wire  pinIn;

  int total = 0, bad = 0;
  int tdivCnt = 0;

  assign pinIn = !(pullLow || btn);   // open-drain line with pull-up

  always #10 clk = ~clk;              // 50 MHz

  rst_seq_gen #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .pwrFail(pwrFail), .pinIn(pinIn), .wdReq(wdReq),
    .oscOff(oscOff), .oscReady(oscReady), .tick(tick),
    .pullLow(pullLow), .inhibit(inhibit)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tdivCnt = (tdivCnt + 1) % TDIV;
    tick <= (tdivCnt == TDIV - 1);
  end

  // ---------------- behavioural reference model ----------------
  int mMode = M_PD;
  int mTicks = 0;
  bit pinHist[$] = '{1'b1, 1'b1, 1'b1};   // [0] newest sample

  function automatic bit mPull(input int m);
    return (m != M_IDLE) && (m != M_REL);
  endfunction

  function automatic string tagOf(input int m);
    case (m)
      M_IDLE: return "R7";
      M_PD:   return "R1";
      M_OSC:  return "R3";
      M_PH:   return "R2";
      M_PB:   return "R4";
      M_WD:   return "R6";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = M_PD; mTicks = 0; pinHist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit pinNow, seen, fell, done;
      int nxt;
      pinNow = !(mPull(mMode) || btn);
      seen   = pinHist[1];
      fell   = (mMode == M_IDLE) && pinHist[2] && !seen;
      done   = tick && (mTicks == HOLD - 1);
      nxt    = mMode;
      if (pwrFail) nxt = M_PD;
      else begin
        case (mMode)
          M_IDLE: if (fell) nxt = M_PB; else if (wdReq) nxt = M_WD;
          M_PD:   nxt = (oscOff && !oscReady) ? M_OSC : M_PH;
          M_OSC:  if (oscReady) nxt = M_PH;
          M_PB:   if (done) nxt = M_REL;
          M_REL:  if (seen) nxt = M_RH;
          default: if (done) nxt = M_IDLE;
        endcase
      end
      if (nxt != mMode) mTicks = 0;
      else if (tick) mTicks++;
      mMode = nxt;
      pinHist.push_front(pinNow);
      void'(pinHist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(pullLow == mPull(mMode), tagOf(mMode), pullLow, mPull(mMode));
      chk(inhibit == (mMode != M_IDLE), "R9", inhibit, mMode != M_IDLE);
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- directed stimulus ----------------
  initial begin
    waitN(3);
    chk(pullLow == 1 && inhibit == 1, "R1 reset state", {pullLow, inhibit}, 3);
    rstN = 1'b1;
    waitN(5);
    chk(pullLow == 1, "R1 power fail", pullLow, 1);
    pwrFail = 1'b0;
    waitN(HT - TDIV - 1);
    chk(pullLow == 1, "R2 hold not done", pullLow, 1);
    waitN(2 * TDIV + 2);
    chk(pullLow == 0, "R2 released", pullLow, 0);
    chk(inhibit == 0, "R9 idle", inhibit, 0);

    // watchdog pulse, with disturbances inside it
    wdReq = 1'b1; waitN(1); wdReq = 1'b0;
    waitN(1);
    chk(pullLow == 1, "R6 start", pullLow, 1);
    btn = 1'b1; waitN(5); btn = 1'b0;
    wdReq = 1'b1; waitN(1); wdReq = 1'b0;
    waitN(HT - 3 * TDIV - 8);
    chk(pullLow == 1, "R6 not truncated", pullLow, 1);
    waitN(3 * TDIV + 4);
    chk(pullLow == 0 && inhibit == 0, "R6 ends", inhibit, 0);
    waitN(20);
    chk(inhibit == 0, "R7 no self trigger", inhibit, 0);

    // pushbutton held past the first hold
    btn = 1'b1;
    waitN(4);
    chk(pullLow == 1, "R4 press", pullLow, 1);
    waitN(HT + TDIV + 4);
    chk(pullLow == 0 && inhibit == 1, "R5 wait release", {pullLow, inhibit}, 1);
    waitN(10);
    chk(inhibit == 1, "R5 still waiting", inhibit, 1);
    btn = 1'b0;
    waitN(6);
    chk(pullLow == 1, "R5 second hold", pullLow, 1);
    waitN(HT + TDIV + 4);
    chk(inhibit == 0, "R5 back to idle", inhibit, 0);
    waitN(20);
    chk(inhibit == 0, "R7 idle stays", inhibit, 0);

    // short press released during first hold
    btn = 1'b1; waitN(10); btn = 1'b0;
    waitN(HT + TDIV + 6);
    chk(pullLow == 1, "R5 release during hold", pullLow, 1);
    waitN(HT + TDIV + 4);
    chk(inhibit == 0, "R5 short press done", inhibit, 0);

    // oscillator startup extension
    pwrFail = 1'b1; oscOff = 1'b1; oscReady = 1'b0;
    waitN(4);
    pwrFail = 1'b0;
    waitN(3 * HT);
    chk(pullLow == 1, "R3 waits oscillator", pullLow, 1);
    oscReady = 1'b1;
    waitN(HT - TDIV - 1);
    chk(pullLow == 1, "R3 hold after ready", pullLow, 1);
    waitN(2 * TDIV + 2);
    chk(pullLow == 0, "R3 released", pullLow, 0);
    oscOff = 1'b0;
    waitN(5);

    // power fail overrides pushbutton
    btn = 1'b1;
    waitN(8);
    pwrFail = 1'b1;
    waitN(2);
    chk(pullLow == 1 && inhibit == 1, "R8 override", pullLow, 1);
    btn = 1'b0;
    waitN(2);
    pwrFail = 1'b0;
    waitN(HT + TDIV + 4);
    chk(inhibit == 0, "R8 restart without pending press", inhibit, 0);
    waitN(10);

    // watchdog request in the same cycle as the detected pin fall
    btn = 1'b1;
    waitN(2);
    wdReq = 1'b1; waitN(1); wdReq = 1'b0;
    waitN(HT + TDIV + 4);
    chk(pullLow == 0 && inhibit == 1, "R10 pushbutton path", {pullLow, inhibit}, 1);
    btn = 1'b0;
    waitN(HT + TDIV + 10);
    chk(inhibit == 0, "R10 completes", inhibit, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule